// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose lines on a simple 32-bit register bus. Each line works in one of three ways. It can be a general input, whose synchronized pin state is readable. It can be a general output, driven from an output data register with its output enable asserted. It can be an interrupt input, which senses a high level, a low level, a rising edge, a falling edge or both edges. All lines share one interrupt request output.

Every pin passes through a two-flop synchronizer before it is read or sensed. For each line there is a status flag, a write-one-to-acknowledge register that clears edge-captured flags, and an enable mask. The mask has two write ports: one that only disables lines and one that only enables them. Software can therefore change one line without a read-modify-write. A polarity register picks active-low or falling-edge sensing. A separate both-edge register makes an edge line capture every transition. The filter on/off location is present but reads as zero.

Top module: `gpio_bank`

## Requirements
- R1: After reset every line is a general input. `pin_oe` and `pin_out` are zero, `irq` is low, and the registers at 0x00, 0x04, 0x08, 0x10, 0x18, 0x20, 0x24, 0x40 and 0x4C read zero.
- R2: A line with 0 at 0x00 and 1 at 0x04 is an output. Its `pin_oe` bit is 1 and its `pin_out` bit equals its bit in the output data register at 0x08. A 1 in the output source register at 0x40 forces that `pin_out` bit to 0.
- R3: 0x0C returns the pin state after two synchronizing flops. It changes within three clock edges of a pin change, and a written 0x08 value reads back unchanged.
- R4: With 1 at 0x00 and 0 at 0x24 (level mode), the line's status bit at 0x10 equals pin XOR its polarity bit at 0x20 (1 means active-low). The bit clears when the level goes away, and writing 0x14 does not clear it.
- R5: With 1 at 0x00, 1 at 0x24 and 0 at 0x20, a 0-to-1 pin transition sets the status bit. The bit stays set after the pin returns low, and a 1-to-0 transition does not set it.
- R6: With 1 at 0x00, 1 at 0x24 and 1 at 0x20, a 1-to-0 transition sets the status bit.
- R7: With 1 at 0x4C on an edge line, both transitions set the status bit, whatever the polarity bit holds.
- R8: Writing 1 to a bit of 0x14 clears that line's edge status. Bits written 0 leave status unchanged. An edge detected in the same cycle as the clear leaves the bit set.
- R9: Writing 0x1C sets the enable bit of each line written 1. Writing 0x18 clears each enable bit written 0 and keeps bits written 1. 0x18 reads 1 for enabled lines.
- R10: `irq` is high exactly when some line has both its status bit and its enable bit set.
- R11: A line with 0 at 0x00 never shows status at 0x10. A line with 1 at 0x00 has `pin_oe` at 0 even if its 0x04 bit is 1.
- R12: 0x14, 0x1C and the filter location 0x28 read zero, and writing 0x28 changes no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge latch with a pending event on one side and an acknowledge on the other. A pin transition has to be timed so that it is detected in the cycle after the acknowledge write. Otherwise the test cannot tell "acknowledge clears" apart from "new edge re-arms". The bench moves pins only between register operations and waits a fixed number of cycles for the synchronizer to settle. It then applies acknowledges with chosen zero and one bits to show which lines are touched. The same-cycle collision is covered by the checker on the internal hit and acknowledge wires.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_MODE   = 8'h00;
  localparam logic [AW-1:0] A_DIR    = 8'h04;
  localparam logic [AW-1:0] A_DOUT   = 8'h08;
  localparam logic [AW-1:0] A_DIN    = 8'h0C;
  localparam logic [AW-1:0] A_STAT   = 8'h10;
  localparam logic [AW-1:0] A_ACK    = 8'h14;
  localparam logic [AW-1:0] A_ENA    = 8'h18;
  localparam logic [AW-1:0] A_UNMASK = 8'h1C;
  localparam logic [AW-1:0] A_POL    = 8'h20;
  localparam logic [AW-1:0] A_TRIG   = 8'h24;
  localparam logic [AW-1:0] A_FILT   = 8'h28;
  localparam logic [AW-1:0] A_SRC    = 8'h40;
  localparam logic [AW-1:0] A_BOTH   = 8'h4C;

  // Level qualification: neg=1 means the line is active when low.
  function automatic logic level_active(input logic s, input logic neg);
    return s ^ neg;
  endfunction

  // Edge qualification from current and previous synchronized samples.
  function automatic logic edge_event(input logic s, input logic p,
                                      input logic neg, input logic both);
    logic rise, fall;
    rise = s & ~p;
    fall = ~s & p;
    if (both) return rise | fall;
    return neg ? fall : rise;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  stat,
  input  logic [N-1:0]  din,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  irq_mode,
  output logic [N-1:0]  dir,
  output logic [N-1:0]  dout,
  output logic [N-1:0]  pol,
  output logic [N-1:0]  trig,
  output logic [N-1:0]  both,
  output logic [N-1:0]  src,
  output logic [N-1:0]  ena,
  output logic [N-1:0]  ack_mask,
  output logic [N-1:0]  unmask_mask
);
  logic [N-1:0] wbits;
  logic         hit_mode, hit_dir, hit_dout, hit_pol, hit_trig;
  logic         hit_both, hit_src, hit_ena, hit_unm, hit_ack;

  assign wbits    = wdata[N-1:0];
  assign hit_mode = we && (addr == A_MODE);
  assign hit_dir  = we && (addr == A_DIR);
  assign hit_dout = we && (addr == A_DOUT);
  assign hit_pol  = we && (addr == A_POL);
  assign hit_trig = we && (addr == A_TRIG);
  assign hit_both = we && (addr == A_BOTH);
  assign hit_src  = we && (addr == A_SRC);
  assign hit_ena  = we && (addr == A_ENA);
  assign hit_unm  = we && (addr == A_UNMASK);
  assign hit_ack  = we && (addr == A_ACK);

  assign ack_mask    = hit_ack ? wbits : '0;
  assign unmask_mask = hit_unm ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mode <= '0;
      dir      <= '0;
      dout     <= '0;
      pol      <= '0;
      trig     <= '0;
      both     <= '0;
      src      <= '0;
    end else begin
      if (hit_mode) irq_mode <= wbits;
      if (hit_dir)  dir      <= wbits;
      if (hit_dout) dout     <= wbits;
      if (hit_pol)  pol      <= wbits;
      if (hit_trig) trig     <= wbits;
      if (hit_both) both     <= wbits;
      if (hit_src)  src      <= wbits;
    end
  end

  // Enable mask: one port only disables, the other only enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ena <= '0;
    else if (hit_ena) ena <= ena & wbits;
    else if (hit_unm) ena <= ena | wbits;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE:  rdata[N-1:0] = irq_mode;
      A_DIR:   rdata[N-1:0] = dir;
      A_DOUT:  rdata[N-1:0] = dout;
      A_DIN:   rdata[N-1:0] = din;
      A_STAT:  rdata[N-1:0] = stat;
      A_ENA:   rdata[N-1:0] = ena;
      A_POL:   rdata[N-1:0] = pol;
      A_TRIG:  rdata[N-1:0] = trig;
      A_SRC:   rdata[N-1:0] = src;
      A_BOTH:  rdata[N-1:0] = both;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] irq_mode,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] both,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] stat,
  output logic [N-1:0] edge_lat,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] edge_cfg
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pin_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic lvl_on;
    assign edge_cfg[i] = irq_mode[i] & trig[i];
    assign edge_hit[i] = edge_cfg[i] & edge_event(pin_s[i], prev[i], pol[i], both[i]);
    assign lvl_on      = irq_mode[i] & ~trig[i] & level_active(pin_s[i], pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            edge_lat[i] <= 1'b0;
      else if (!edge_cfg[i]) edge_lat[i] <= 1'b0;
      else                   edge_lat[i] <= (edge_lat[i] & ~ack_mask[i]) | edge_hit[i];
    end

    assign stat[i] = edge_cfg[i] ? edge_lat[i] : lvl_on;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NLINES-1:0]   pin_in,
  output logic [NLINES-1:0]   pin_out,
  output logic [NLINES-1:0]   pin_oe,
  output logic                irq
);
  logic [NLINES-1:0] pin_s, stat, irq_mode, dir, dout, pol, trig, both, src;
  logic [NLINES-1:0] ena, ack_mask, unmask_mask, edge_lat, edge_hit, edge_cfg;

  gpio_sync #(.W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pin_s)
  );

  gpio_regs #(.N(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .stat(stat), .din(pin_s), .rdata(bus_rdata), .irq_mode(irq_mode), .dir(dir),
    .dout(dout), .pol(pol), .trig(trig), .both(both), .src(src), .ena(ena),
    .ack_mask(ack_mask), .unmask_mask(unmask_mask)
  );

  gpio_sense #(.N(NLINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .irq_mode(irq_mode), .pol(pol),
    .trig(trig), .both(both), .ack_mask(ack_mask), .stat(stat),
    .edge_lat(edge_lat), .edge_hit(edge_hit), .edge_cfg(edge_cfg)
  );

  assign pin_oe  = ~irq_mode & dir;
  assign pin_out = pin_oe & dout & ~src;
  assign irq     = |(stat & ena);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] irq_mode,
  input logic [N-1:0] stat,
  input logic [N-1:0] ena,
  input logic [N-1:0] edge_lat,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] edge_cfg,
  input logic [N-1:0] ack_mask,
  input logic [N-1:0] unmask_mask
);
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_lat) & ~$past(ack_mask) & $past(edge_cfg)) & ~edge_lat) == '0)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ack_mask) & ~$past(edge_hit)) & edge_lat) == '0)); // R8
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_hit) & $past(edge_cfg)) & ~edge_lat) == '0)); // R8
  AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(unmask_mask) & ~ena) == '0)); // R9
  AST_NO_ENA_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == '0) |-> !irq); // R10
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0)); // R10
  AST_IRQLINE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & irq_mode) == '0); // R11
  AST_IO_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~irq_mode) == '0); // R11
endmodule

bind gpio_bank gpio_bank_chk #(.N(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pin_oe(pin_oe), .irq_mode(irq_mode),
  .stat(stat), .ena(ena), .edge_lat(edge_lat), .edge_hit(edge_hit),
  .edge_cfg(edge_cfg), .ack_mask(ack_mask), .unmask_mask(unmask_mask)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    foreach (v[i]) begin end
    rd(8'h00, v); chk("R1 mode", v, 0);
    rd(8'h04, v); chk("R1 dir", v, 0);
    rd(8'h08, v); chk("R1 dout", v, 0);
    rd(8'h10, v); chk("R1 stat", v, 0);
    rd(8'h18, v); chk("R1 ena", v, 0);
    rd(8'h20, v); chk("R1 pol", v, 0);
    rd(8'h24, v); chk("R1 trig", v, 0);
    rd(8'h40, v); chk("R1 src", v, 0);
    rd(8'h4C, v); chk("R1 both", v, 0);
  endtask

  task automatic t_output;
    logic [31:0] v;
    wr(8'h04, 32'h0000_0002);
    wr(8'h08, 32'h0000_0006);
    #1;
    chk("R2 oe", pin_oe, 32'h2);
    chk("R2 out", pin_out, 32'h2);
    rd(8'h08, v); chk("R3 dout readback", v, 32'h6);
    wr(8'h40, 32'h0000_0002);
    #1 chk("R2 src forces low", pin_out, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h08, 32'h0);
    #1 chk("R2 out follows dout", pin_out, 32'h0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_input;
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'hA5A5_0F00;
    rd(8'h0C, v); chk("R3 not before sync", v, 32'h0);
    repeat (2) @(negedge clk);
    rd(8'h0C, v); chk("R3 din", v, 32'hA5A5_0F00);
    rd(8'h10, v); chk("R11 io lines no status", v, 32'h0);
    set_pins(32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(8'h00, 32'h8);
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    set_pins(32'h8);
    rd(8'h10, v); chk("R4 high level", v, 32'h8);
    wr(8'h14, 32'h8);
    rd(8'h10, v); chk("R4 ack ignored on level", v, 32'h8);
    set_pins(32'h0);
    rd(8'h10, v); chk("R4 level gone", v, 32'h0);
    wr(8'h20, 32'h8);
    rd(8'h10, v); chk("R4 low level active", v, 32'h8);
    wr(8'h20, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    wr(8'h00, 32'h20);
    wr(8'h24, 32'h20);
    set_pins(32'h20);
    rd(8'h10, v); chk("R5 rise sets", v, 32'h20);
    set_pins(32'h0);
    rd(8'h10, v); chk("R5 sticky", v, 32'h20);
    wr(8'h14, 32'hFFFF_FFDF);
    rd(8'h10, v); chk("R8 zero bits no effect", v, 32'h20);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R8 ack clears", v, 32'h0);
    set_pins(32'h20);
    wr(8'h14, 32'h20);
    set_pins(32'h0);
    rd(8'h10, v); chk("R5 fall ignored", v, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    wr(8'h00, 32'h0);
    set_pins(32'h40);
    wr(8'h20, 32'h40);
    wr(8'h24, 32'h40);
    wr(8'h00, 32'h40);
    wr(8'h14, 32'h40);
    rd(8'h10, v); chk("R6 quiet", v, 32'h0);
    set_pins(32'h0);
    rd(8'h10, v); chk("R6 fall sets", v, 32'h40);
    wr(8'h14, 32'h40);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(8'h00, 32'h80);
    wr(8'h24, 32'h80);
    wr(8'h20, 32'h80);
    wr(8'h4C, 32'h80);
    wr(8'h14, 32'hFFFF_FFFF);
    set_pins(32'h80);
    rd(8'h10, v); chk("R7 rise with neg pol", v, 32'h80);
    wr(8'h14, 32'h80);
    rd(8'h10, v); chk("R8 cleared", v, 32'h0);
    set_pins(32'h0);
    rd(8'h10, v); chk("R7 fall", v, 32'h80);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    #1 chk("R10 masked no irq", {31'h0, irq}, 32'h0);
    wr(8'h1C, 32'h84);
    rd(8'h18, v); chk("R9 unmask", v, 32'h84);
    chk("R10 irq on", {31'h0, irq}, 32'h1);
    wr(8'h18, 32'hFFFF_FF7F);
    rd(8'h18, v); chk("R9 mask write", v, 32'h04);
    chk("R10 irq off", {31'h0, irq}, 32'h0);
    wr(8'h1C, 32'h80);
    #1 chk("R10 irq again", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h80);
    #1 chk("R10 irq after ack", {31'h0, irq}, 32'h0);
    rd(8'h1C, v); chk("R12 unmask reads 0", v, 0);
    rd(8'h14, v); chk("R12 ack reads 0", v, 0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    wr(8'h00, 32'h200);
    wr(8'h04, 32'h200);
    #1 chk("R11 irq line no oe", pin_oe, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R12 filter reads 0", v, 0);
    rd(8'h00, v); chk("R12 mode unchanged", v, 32'h200);
    rd(8'h18, v); chk("R12 ena unchanged", v, 32'h84);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_misc();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule